// File: doc/BRIEF.md
# Delay-Doppler Frame Modulator (8 x 8)

This block turns a serial stream of binary antipodal symbols into the time-domain samples of one 8 by 8 delay-Doppler frame. Sixty-four symbols are accepted one per clock whenever the input strobe is high. Each symbol becomes a real value of +1 or -1 and is placed in a 64-entry frame buffer. Once the 64th symbol arrives, the frame goes through three fully parallel transform layers. Each layer is eight 8-point radix-2 engines. Each butterfly stage has a register level, so the pipeline holds nine stages.

The first layer runs inverse transforms over the upper three bits of the 6-bit symbol index. The second layer runs forward transforms over the lower three bits. Together these two layers form the symplectic pre-transform. Because the transmit window is all ones, nothing is multiplied between the second and third layers. The third layer runs inverse transforms over the lower three bits again, which is the time-domain conversion. A serialiser then emits the 64 complex results one per clock, and a start flag marks the first sample of each frame. A new frame can be loaded while the previous frame is still being emitted.

Top module: `otfs_tx_core`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `out_first` stay low until a frame has been fully loaded and has crossed the pipeline.
- R2: A symbol is accepted only on a clock edge where `sym_valid` is high. Bit 1 of the 2-bit code selects the value: 0 gives +1 (codes 2'b01 and 2'b00), and 1 gives -1 (codes 2'b11 and 2'b10). The n-th accepted symbol of a frame is frame element n, with n from 0 to 63.
- R3: Write element index n as 8h+l. Layer one computes y[8h+l] = sum over t of x[8t+l]·e^(+j2πth/8). Layer two computes z[8h+f] = sum over l of y[8h+l]·e^(-j2πlf/8). Layer three computes s[8h+m] = sum over f of z[8h+f]·e^(+j2πfm/8). No transform is normalised. Each output is a 27-bit two's-complement real part and imaginary part with 14 fraction bits, and each is within 1024 LSB of the exact value.
- R4: The first output sample of a frame is valid exactly 10 clock edges after the edge that accepts that frame's 64th symbol, and `out_first` is high in that cycle only.
- R5: Each frame produces exactly 64 consecutive valid samples, s[0] through s[63], in natural index order. `out_first` is never high without `out_valid`.
- R6: When a new frame completes loading while an earlier frame is still being emitted, the earlier frame finishes intact. If the input strobe runs without a break, the output samples follow one another with no idle cycle.
- R7: Cycles with `sym_valid` low neither advance the load position nor change the buffered frame.
- R8: A frame of 64 symbols that are all +1 yields 64.0 (1048576 LSB) on the real part of samples 0 to 7, and zero on every other part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid | input | 1 | High when `sym_in` carries a symbol |
| sym_in | input | 2 | Antipodal symbol code; bit 1 is the sign |
| out_valid | output | 1 | High when an output sample is presented |
| out_first | output | 1 | High with the first sample of a frame |
| out_re | output | 27 | Real part of the sample, 14 fraction bits |
| out_im | output | 27 | Imaginary part of the sample, 14 fraction bits |

## Verification
The bench sends frames of all +1, all -1, alternating signs written with the less common codes, and random symbols. Some random frames have strobe gaps and some run back to back. Each frame's reference is the literal three-layer nested sum, which shows up a wrong twiddle sign, a swapped index field or a missing bit reversal as errors of whole units in many samples. The strobe gaps catch a loader that counts idle cycles, which would shift every symbol after the gap. The back-to-back frames catch a serialiser that drops or repeats samples when it reloads on the last index of the previous frame. Counting the exact latency edge catches any pipeline stage that is missing or doubled.

// File: rtl/otfs_pkg.sv
package otfs_pkg;
   localparam int SAMP_W  = 27;
   localparam int LOG_NPT = 3;
   localparam int NPT     = 1 << LOG_NPT;
   localparam int IDX_W   = 2 * LOG_NPT;
   localparam int FRAME   = NPT * NPT;

   typedef logic signed [SAMP_W-1:0] samp_t;
   typedef struct packed {
      samp_t re;
      samp_t im;
   } cplx_t;

   function automatic logic [LOG_NPT-1:0] bitrev(input logic [LOG_NPT-1:0] v);
      logic [LOG_NPT-1:0] r;
      for (int i = 0; i < LOG_NPT; i++) r[i] = v[LOG_NPT-1-i];
      return r;
   endfunction
endpackage

// File: rtl/otfs_r2_stage.sv
module otfs_r2_stage import otfs_pkg::*; #(
   parameter int STG       = 0,
   parameter bit INV       = 1'b0,
   parameter int ROT_COEF  = 46341,
   parameter int ROT_SHIFT = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  vld_i,
   input  cplx_t d_i [NPT],
   output logic  vld_o,
   output cplx_t d_o [NPT]
);
   localparam int HALF    = (NPT / 2) >> STG;
   localparam int TW_STEP = 1 << STG;

   function automatic samp_t scale(input samp_t x);
      logic signed [63:0] p;
      p = 64'(x) * 64'(ROT_COEF);
      return samp_t'(p >>> ROT_SHIFT);
   endfunction

   function automatic cplx_t rot_fwd(input cplx_t z, input int e);
      cplx_t r;
      case (e)
         1:       begin r.re = scale(z.re + z.im);  r.im = scale(z.im - z.re);  end
         2:       begin r.re = z.im;                r.im = -z.re;               end
         3:       begin r.re = scale(z.im - z.re);  r.im = scale(-z.re - z.im); end
         default: r = z;
      endcase
      return r;
   endfunction

   function automatic cplx_t rot(input cplx_t z, input int e);
      cplx_t q;
      cplx_t r;
      q = z;
      if (INV) q.im = -z.im;
      r = rot_fwd(q, e);
      if (INV) r.im = -r.im;
      return r;
   endfunction

   cplx_t nxt [NPT];

   always_comb begin
      for (int i = 0; i < NPT; i++) begin
         if ((i & HALF) == 0) begin
            nxt[i].re = d_i[i].re + d_i[i | HALF].re;
            nxt[i].im = d_i[i].im + d_i[i | HALF].im;
         end else begin
            cplx_t df;
            df.re  = d_i[i & ~HALF].re - d_i[i].re;
            df.im  = d_i[i & ~HALF].im - d_i[i].im;
            nxt[i] = rot(df, ((i & ~HALF) % HALF) * TW_STEP);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_o <= 1'b0;
      else        vld_o <= vld_i;
   end

   always_ff @(posedge clk) begin
      d_o <= nxt;
   end
endmodule

// File: rtl/otfs_xform8.sv
module otfs_xform8 import otfs_pkg::*; #(
   parameter bit INV       = 1'b0,
   parameter int ROT_COEF  = 46341,
   parameter int ROT_SHIFT = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  vld_i,
   input  cplx_t d_i [NPT],
   output logic  vld_o,
   output cplx_t d_o [NPT]
);
   cplx_t            lane [1:LOG_NPT][NPT];
   logic [LOG_NPT:1] vq;

   for (genvar s = 0; s < LOG_NPT; s++) begin : g_stg
      if (s == 0) begin : g_head
         otfs_r2_stage #(.STG(s), .INV(INV), .ROT_COEF(ROT_COEF), .ROT_SHIFT(ROT_SHIFT)) u_stg (
            .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .d_i(d_i),
            .vld_o(vq[s+1]), .d_o(lane[s+1]));
      end else begin : g_body
         otfs_r2_stage #(.STG(s), .INV(INV), .ROT_COEF(ROT_COEF), .ROT_SHIFT(ROT_SHIFT)) u_stg (
            .clk(clk), .rst_n(rst_n), .vld_i(vq[s]), .d_i(lane[s]),
            .vld_o(vq[s+1]), .d_o(lane[s+1]));
      end
   end

   always_comb begin
      for (int k = 0; k < NPT; k++) d_o[k] = lane[LOG_NPT][bitrev(LOG_NPT'(k))];
   end

   assign vld_o = vq[LOG_NPT];
endmodule

// File: rtl/otfs_s2p.sv
module otfs_s2p import otfs_pkg::*; (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_valid,
   input  logic [1:0]       sym_in,
   output logic             done,
   output logic [FRAME-1:0] neg_q
);
   logic [IDX_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= sym_valid && (cnt_q == IDX_W'(FRAME-1));
         if (sym_valid) cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (sym_valid) neg_q[cnt_q] <= sym_in[1];
   end

   AST_DONE_NEEDS_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(sym_valid)); // R7
endmodule

// File: rtl/otfs_p2s.sv
module otfs_p2s import otfs_pkg::*; (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  vld_i,
   input  cplx_t d_i [FRAME],
   output logic  out_valid,
   output logic  out_first,
   output cplx_t out_s
);
   cplx_t            hold_q [FRAME];
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_first <= 1'b0;
         idx_q     <= '0;
      end else if (vld_i) begin
         out_valid <= 1'b1;
         out_first <= 1'b1;
         idx_q     <= '0;
      end else begin
         out_first <= 1'b0;
         if (out_valid) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(FRAME-1)) out_valid <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (vld_i) hold_q <= d_i;
   end

   assign out_s = hold_q[idx_q];

   AST_FIRST_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_first |-> out_valid); // R5
   AST_START_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> out_first); // R5
   AST_INDEX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_first && $past(out_valid)) |-> (idx_q == $past(idx_q) + 1'b1)); // R5
endmodule

// File: rtl/otfs_tx_core.sv
module otfs_tx_core import otfs_pkg::*; #(
   parameter int ONE_SHIFT = 14,
   parameter int ROT_COEF  = 46341,
   parameter int ROT_SHIFT = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sym_valid,
   input  logic [1:0]               sym_in,
   output logic                     out_valid,
   output logic                     out_first,
   output logic signed [SAMP_W-1:0] out_re,
   output logic signed [SAMP_W-1:0] out_im
);
   localparam int    GROWTH = 3 * LOG_NPT;
   localparam samp_t ONE    = samp_t'(1 << ONE_SHIFT);

   if (SAMP_W < ONE_SHIFT + GROWTH + 2) begin : g_chk_w
      $error("sample width too small for the frame growth");
   end
   if (ROT_COEF <= 0 || ROT_COEF >= (1 << ROT_SHIFT)) begin : g_chk_c
      $error("rotation coefficient must lie in (0,1)");
   end

   logic             done;
   logic [FRAME-1:0] neg_q;

   otfs_s2p u_s2p (.clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_in(sym_in),
                   .done(done), .neg_q(neg_q));

   cplx_t a_in [NPT][NPT];
   cplx_t a_o  [NPT][NPT];
   cplx_t b_in [NPT][NPT];
   cplx_t b_o  [NPT][NPT];
   cplx_t c_o  [NPT][NPT];
   cplx_t flat [FRAME];
   logic [NPT-1:0] a_v, b_v, c_v;
   logic a_all, b_all, c_all;

   always_comb begin
      for (int j = 0; j < NPT; j++) begin
         for (int t = 0; t < NPT; t++) begin
            a_in[j][t].re = neg_q[NPT*t + j] ? -ONE : ONE;
            a_in[j][t].im = '0;
            b_in[j][t]    = a_o[t][j];
            flat[NPT*j + t] = c_o[j][t];
         end
      end
   end

   assign a_all = &a_v;
   assign b_all = &b_v;
   assign c_all = &c_v;

   for (genvar g = 0; g < NPT; g++) begin : g_lane
      otfs_xform8 #(.INV(1'b1), .ROT_COEF(ROT_COEF), .ROT_SHIFT(ROT_SHIFT)) u_dd (
         .clk(clk), .rst_n(rst_n), .vld_i(done), .d_i(a_in[g]), .vld_o(a_v[g]), .d_o(a_o[g]));
      otfs_xform8 #(.INV(1'b0), .ROT_COEF(ROT_COEF), .ROT_SHIFT(ROT_SHIFT)) u_tf (
         .clk(clk), .rst_n(rst_n), .vld_i(a_all), .d_i(b_in[g]), .vld_o(b_v[g]), .d_o(b_o[g]));
      otfs_xform8 #(.INV(1'b1), .ROT_COEF(ROT_COEF), .ROT_SHIFT(ROT_SHIFT)) u_ht (
         .clk(clk), .rst_n(rst_n), .vld_i(b_all), .d_i(b_o[g]), .vld_o(c_v[g]), .d_o(c_o[g]));
   end

   cplx_t out_s;

   otfs_p2s u_p2s (.clk(clk), .rst_n(rst_n), .vld_i(c_all), .d_i(flat),
                   .out_valid(out_valid), .out_first(out_first), .out_s(out_s));

   assign out_re = out_s.re;
   assign out_im = out_s.im;

   AST_PIPE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ##9 c_all); // R4
endmodule

// File: tb/otfs_tx_core_test.sv
module otfs_tx_core_test;
   localparam int  TOL   = 1024;
   localparam real SCALE = 16384.0;
   localparam real PI    = 3.14159265358979;
   localparam int  NFR   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sym_valid = 1'b0;
   logic [1:0] sym_in = 2'b00;
   logic out_valid, out_first;
   logic signed [26:0] out_re, out_im;

   always #4 clk = ~clk;

   otfs_tx_core uut (.clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_in(sym_in),
                     .out_valid(out_valid), .out_first(out_first),
                     .out_re(out_re), .out_im(out_im));

   int  total = 0;
   int  bad   = 0;
   int  edge_n = 0;
   int  nfr = 0;
   bit  run_chk = 1'b0;
   int  start_e [NFR];
   real ref_re [NFR][64];
   real ref_im [NFR][64];

   always @(posedge clk) edge_n <= edge_n + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d (edge %0d)", req, what, act, exp, edge_n);
      end
   endtask

   task automatic compute_ref(input int f, input logic [63:0] neg);
      real xr [64];
      real yr [64], yi [64], zr [64], zi [64];
      for (int n = 0; n < 64; n++) xr[n] = neg[n] ? -1.0 : 1.0;
      for (int h = 0; h < 8; h++)
         for (int l = 0; l < 8; l++) begin
            yr[8*h+l] = 0.0; yi[8*h+l] = 0.0;
            for (int t = 0; t < 8; t++) begin
               yr[8*h+l] += xr[8*t+l] * $cos(2.0*PI*t*h/8.0);
               yi[8*h+l] += xr[8*t+l] * $sin(2.0*PI*t*h/8.0);
            end
         end
      for (int h = 0; h < 8; h++)
         for (int q = 0; q < 8; q++) begin
            zr[8*h+q] = 0.0; zi[8*h+q] = 0.0;
            for (int l = 0; l < 8; l++) begin
               real c, s;
               c = $cos(2.0*PI*l*q/8.0); s = -$sin(2.0*PI*l*q/8.0);
               zr[8*h+q] += yr[8*h+l]*c - yi[8*h+l]*s;
               zi[8*h+q] += yr[8*h+l]*s + yi[8*h+l]*c;
            end
         end
      for (int h = 0; h < 8; h++)
         for (int m = 0; m < 8; m++) begin
            real ar, ai;
            ar = 0.0; ai = 0.0;
            for (int q = 0; q < 8; q++) begin
               real c, s;
               c = $cos(2.0*PI*q*m/8.0); s = $sin(2.0*PI*q*m/8.0);
               ar += zr[8*h+q]*c - zi[8*h+q]*s;
               ai += zr[8*h+q]*s + zi[8*h+q]*c;
            end
            ref_re[f][8*h+m] = ar * SCALE;
            ref_im[f][8*h+m] = ai * SCALE;
         end
   endtask

   // mode: 0 all +1, 1 all -1, 2 alternating with codes 00/10, 3 random with gaps, 4 random
   task automatic send_frame(input int mode);
      logic [63:0] neg;
      for (int n = 0; n < 64; n++) begin
         logic [1:0] code;
         case (mode)
            0: code = 2'b01;
            1: code = 2'b11;
            2: code = n[0] ? 2'b10 : 2'b00;
            default: code = $urandom_range(0, 1) ? 2'b11 : 2'b01;
         endcase
         neg[n] = code[1];
         if (mode == 3 && (n % 5) == 2) begin
            sym_valid = 1'b0;
            sym_in    = ~code;
            @(negedge clk);
            @(negedge clk);
         end
         sym_valid = 1'b1;
         sym_in    = code;
         if (n == 63) begin
            @(posedge clk);
            #1;
            compute_ref(nfr, neg);
            start_e[nfr] = edge_n + 10;
            nfr++;
            @(negedge clk);
         end else begin
            @(negedge clk);
         end
      end
      sym_valid = 1'b0;
      sym_in    = 2'b00;
   endtask

   function automatic string data_req(input int f);
      case (f)
         0: return "R8";
         2: return "R2";
         3: return "R7";
         1: return "R3";
         default: return "R6";
      endcase
   endfunction

   always @(negedge clk) begin
      int f;
      int k;
      if (run_chk) begin
         f = -1;
         for (int q = 0; q < nfr; q++)
            if (edge_n >= start_e[q] && edge_n < start_e[q] + 64) f = q;
         if (f < 0) begin
            check(out_valid === 1'b0, (nfr == 0) ? "R1" : "R5", "idle valid", longint'(out_valid), 0);
            check(out_first === 1'b0, (nfr == 0) ? "R1" : "R5", "idle first", longint'(out_first), 0);
         end else begin
            k = edge_n - start_e[f];
            check(out_valid === 1'b1, (k == 0) ? "R4" : ((f >= 4) ? "R6" : "R5"), "valid",
                  longint'(out_valid), 1);
            check(out_first === (k == 0), (k == 0) ? "R4" : "R5", "first flag",
                  longint'(out_first), longint'(k == 0));
            begin
               longint er, ei;
               er = longint'($rtoi(ref_re[f][k] + ((ref_re[f][k] >= 0.0) ? 0.5 : -0.5)));
               ei = longint'($rtoi(ref_im[f][k] + ((ref_im[f][k] >= 0.0) ? 0.5 : -0.5)));
               check((longint'(out_re) - er <= TOL) && (er - longint'(out_re) <= TOL),
                     data_req(f), "real part", longint'(out_re), er);
               check((longint'(out_im) - ei <= TOL) && (ei - longint'(out_im) <= TOL),
                     data_req(f), "imag part", longint'(out_im), ei);
               if (f == 0) begin
                  check((longint'(out_re) - ((k < 8) ? 1048576 : 0) <= TOL) &&
                        (((k < 8) ? 1048576 : 0) - longint'(out_re) <= TOL),
                        "R8", "closed form real", longint'(out_re), (k < 8) ? 1048576 : 0);
               end
            end
         end
      end
   end

   initial begin
      for (int q = 0; q < NFR; q++) start_e[q] = 32'h7fff_0000;
      repeat (3) @(negedge clk);
      check(out_valid === 1'b0 && out_first === 1'b0, "R1", "valid/first in reset",
            longint'({out_valid, out_first}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_chk = 1'b1;
      send_frame(0);
      repeat (80) @(negedge clk);
      send_frame(1);
      send_frame(2);
      send_frame(3);
      send_frame(4);
      send_frame(4);
      send_frame(4);
      send_frame(4);
      repeat (100) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule